// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block moves bytes of firmware-configuration items into system memory under the control of descriptors held in memory. A host rings a write-only doorbell with the 64-bit address of a 16-byte descriptor. The engine then reads the descriptor over a byte-wide request/acknowledge memory master port. It may switch to another configuration item, and it then copies item bytes to a target buffer or skips over them. When the work is finished, it writes a completion word back into the descriptor.

The descriptor is big-endian. Bytes 0..3 hold a control word, bytes 4..7 hold a byte count, and bytes 8..15 hold the 64-bit target address. A small built-in item store holds a parameterised number of items, each with a parameterised length. The store is indexed by a 16-bit selector. It remembers the current item and the byte offset inside it, so that successive transfers continue where the previous one stopped.

Top module: `cfgdma_engine`

## Requirements
- R1: The doorbell takes writes only and decodes them by size and offset. A 4-byte write (db_size=4) at db_off=0 loads address bits 63:32 from db_wdata[31:0]. A 4-byte write at db_off=4 ORs db_wdata[31:0] into bits 31:0 and starts a transfer. An 8-byte write at db_off=0 loads all 64 bits and starts a transfer. Any other size or offset has no effect.
- R2: On every start, the doorbell register is cleared to zero. A later 4-byte write at offset 4 on its own therefore starts from an address whose upper 32 bits are zero.
- R3: After a start, the engine reads the 16 descriptor bytes one request at a time, from addresses desc..desc+15 in ascending order. It assembles each field most-significant byte first. A request holds its address, direction and data until it is acknowledged.
- R4: If any descriptor read returns an error, the engine writes nothing to the target. It writes bytes 00 00 00 01 to desc..desc+3 and ends the transfer.
- R5: Control bit 3 (0x08) selects the item numbered control[31:16] and resets the item offset to zero. This also happens when neither bit 1 nor bit 2 is set.
- R6: Control bit 1 (0x02) requests a read. The engine writes the byte count to target, target+1, and so on. A byte at offset k of item i is (i*37 + k + 1) mod 256. Bytes past the item's end, or from a selector at or above the item count, are written as zero and leave the offset unchanged.
- R7: When bit 1 is clear and control bit 2 (0x04) is set, no target bytes are written. The item offset advances by the smaller of the byte count and the bytes left in the item.
- R8: When neither bit 1 nor bit 2 is set, no target bytes are written and the offset does not change.
- R9: Without a select, the item and the offset carry over from one transfer to the next.
- R10: A target-write error stops the copy at once, with no further target writes. The completion word is then 00 00 00 01.
- R11: A transfer without an error ends by writing 00 00 00 00 to desc..desc+3.
- R12: busy rises on the cycle after a starting doorbell write and falls after the last completion byte is acknowledged. Doorbell writes that arrive while busy is high are ignored.
- R13: After reset, busy and mem_req are low, the current item is 0 and the offset is 0. With the default parameters, item 0 is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| db_wr | input | 1 | Doorbell write strobe, one cycle |
| db_off | input | 3 | Byte offset of the doorbell write |
| db_size | input | 4 | Doorbell write size in bytes |
| db_wdata | input | 64 | Doorbell write value, numeric (already byte-swapped) |
| busy | output | 1 | A transfer is in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Request completed, one cycle |
| mem_err | input | 1 | Request failed, valid with mem_ack |

## Verification
The hardest state to reach is an item offset that sits partway through an item, at the same moment as a read whose length runs past the item's end. That state depends on the history of earlier transfers and is not visible at any port. The bench reaches it with a chain of transfers: a select-and-read, a read without a select, then a skip. It predicts the offset independently from the item lengths, and finally reads a span that crosses into the zero-fill region. Errors are injected by making the memory model fail one chosen address, once in the middle of the descriptor and once in the middle of the target buffer.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

   localparam int ADDR_W = 64;
   localparam int SEL_W  = 16;
   localparam int CNT_W  = 32;

   localparam int CTL_ERR_BIT  = 0;
   localparam int CTL_READ_BIT = 1;
   localparam int CTL_SKIP_BIT = 2;
   localparam int CTL_SEL_BIT  = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DECODE,
      ST_PLAN,
      ST_XFER,
      ST_STATUS
   } seq_state_t;

   function automatic logic [7:0] item_byte(input logic [SEL_W-1:0] sel,
                                            input logic [CNT_W-1:0] off);
      logic [7:0] prod;
      prod = sel[7:0] * 8'd37;
      return prod + off[7:0] + 8'd1;
   endfunction

endpackage

// File: rtl/cfgdma_doorbell.sv
module cfgdma_doorbell
   import cfgdma_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        off,
   input  logic [3:0]        size,
   input  logic [63:0]       wdata,
   input  logic              busy,
   output logic              start,
   output logic [ADDR_W-1:0] start_addr
);

   logic [ADDR_W-1:0] bell_q;
   logic              hi_load;
   logic              lo_go;
   logic              full_go;

   assign hi_load = wr && !busy && (size == 4'd4) && (off == 3'd0);
   assign lo_go   = wr && !busy && (size == 4'd4) && (off == 3'd4);
   assign full_go = wr && !busy && (size == 4'd8) && (off == 3'd0);
   assign start   = lo_go || full_go;

   always_comb begin
      if (full_go) start_addr = wdata;
      else         start_addr = bell_q | {32'd0, wdata[31:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bell_q <= '0;
      else if (start)   bell_q <= '0;
      else if (hi_load) bell_q <= {wdata[31:0], 32'd0};
   end

endmodule

// File: rtl/cfgdma_items.sv
module cfgdma_items
   import cfgdma_pkg::*;
#(
   parameter int                      NUM_ITEMS = 4,
   parameter logic [16*NUM_ITEMS-1:0] ITEM_LENS = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_load,
   input  logic [SEL_W-1:0] sel_val,
   input  logic             adv_one,
   input  logic             adv_en,
   input  logic [CNT_W-1:0] adv_amt,
   output logic             has_data,
   output logic [7:0]       cur_byte,
   output logic [CNT_W-1:0] remain
);

   initial begin
      if (NUM_ITEMS < 1 || NUM_ITEMS > 256)
         $error("cfgdma_items: NUM_ITEMS must be within 1..256");
   end

   logic [CNT_W-1:0] len_tab [NUM_ITEMS];

   for (genvar g = 0; g < NUM_ITEMS; g++) begin : g_len
      assign len_tab[g] = {16'd0, ITEM_LENS[16*g +: 16]};
   end

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] off_q;
   logic [CNT_W-1:0] cur_len;

   always_comb begin
      cur_len = '0;
      for (int i = 0; i < NUM_ITEMS; i++) begin
         if (sel_q == SEL_W'(i)) cur_len = len_tab[i];
      end
   end

   assign has_data = off_q < cur_len;
   assign remain   = has_data ? (cur_len - off_q) : '0;
   assign cur_byte = item_byte(sel_q, off_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         off_q <= '0;
      end else if (sel_load) begin
         sel_q <= sel_val;
         off_q <= '0;
      end else if (adv_en) begin
         off_q <= off_q + adv_amt;
      end else if (adv_one && has_data) begin
         off_q <= off_q + 1'b1;
      end
   end

endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
   import cfgdma_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              sel_load,
   output logic [SEL_W-1:0]  sel_val,
   output logic              adv_one,
   output logic              adv_en,
   output logic [CNT_W-1:0]  adv_amt,
   input  logic              has_data,
   input  logic [7:0]        cur_byte,
   input  logic [CNT_W-1:0]  remain
);

   localparam int DESC_BYTES = 16;
   localparam int DESC_BITS  = DESC_BYTES * 8;
   localparam int STAT_BYTES = 4;

   seq_state_t           state_q;
   logic [ADDR_W-1:0]    desc_q;
   logic [DESC_BITS-1:0] shift_q;
   logic [3:0]           cnt_q;
   logic [CNT_W-1:0]     len_q;
   logic [ADDR_W-1:0]    tgt_q;
   logic                 fail_q;
   logic                 rd_mode_q;
   logic                 sk_mode_q;

   logic [31:0]          ctl_w;
   logic [CNT_W-1:0]     skip_amt;

   assign ctl_w    = shift_q[DESC_BITS-1 -: 32];
   assign skip_amt = (len_q < remain) ? len_q : remain;

   assign busy    = state_q != ST_IDLE;
   assign mem_req = (state_q == ST_FETCH) || (state_q == ST_XFER) ||
                    (state_q == ST_STATUS);
   assign mem_we  = (state_q == ST_XFER) || (state_q == ST_STATUS);

   always_comb begin
      mem_addr  = desc_q + {60'd0, cnt_q};
      mem_wdata = 8'd0;
      if (state_q == ST_XFER) begin
         mem_addr  = tgt_q;
         mem_wdata = has_data ? cur_byte : 8'd0;
      end else if (state_q == ST_STATUS && cnt_q == 4'(STAT_BYTES - 1)) begin
         mem_wdata = {7'd0, fail_q};
      end
   end

   assign sel_load = (state_q == ST_DECODE) && ctl_w[CTL_SEL_BIT];
   assign sel_val  = ctl_w[31:16];
   assign adv_one  = (state_q == ST_XFER) && mem_ack && !mem_err;
   assign adv_en   = (state_q == ST_PLAN) && !rd_mode_q && sk_mode_q;
   assign adv_amt  = skip_amt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         desc_q    <= '0;
         shift_q   <= '0;
         cnt_q     <= '0;
         len_q     <= '0;
         tgt_q     <= '0;
         fail_q    <= 1'b0;
         rd_mode_q <= 1'b0;
         sk_mode_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  desc_q  <= start_addr;
                  cnt_q   <= '0;
                  fail_q  <= 1'b0;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     fail_q  <= 1'b1;
                     cnt_q   <= '0;
                     state_q <= ST_STATUS;
                  end else begin
                     shift_q <= {shift_q[DESC_BITS-9:0], mem_rdata};
                     cnt_q   <= cnt_q + 1'b1;
                     if (cnt_q == 4'(DESC_BYTES - 1)) state_q <= ST_DECODE;
                  end
               end
            end
            ST_DECODE: begin
               len_q     <= shift_q[95:64];
               tgt_q     <= shift_q[63:0];
               rd_mode_q <= ctl_w[CTL_READ_BIT];
               sk_mode_q <= ctl_w[CTL_SKIP_BIT];
               state_q   <= ST_PLAN;
            end
            ST_PLAN: begin
               cnt_q <= '0;
               if (rd_mode_q && len_q != '0) state_q <= ST_XFER;
               else                          state_q <= ST_STATUS;
            end
            ST_XFER: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     fail_q  <= 1'b1;
                     state_q <= ST_STATUS;
                  end else begin
                     tgt_q <= tgt_q + 1'b1;
                     len_q <= len_q - 1'b1;
                     if (len_q == CNT_W'(1)) state_q <= ST_STATUS;
                  end
               end
            end
            ST_STATUS: begin
               if (mem_ack) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == 4'(STAT_BYTES - 1)) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
   import cfgdma_pkg::*;
#(
   parameter int                      NUM_ITEMS = 4,
   parameter logic [16*NUM_ITEMS-1:0] ITEM_LENS = 64'h0003_000C_0005_0000
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        db_wr,
   input  logic [2:0]  db_off,
   input  logic [3:0]  db_size,
   input  logic [63:0] db_wdata,
   output logic        busy,
   output logic        mem_req,
   output logic        mem_we,
   output logic [63:0] mem_addr,
   output logic [7:0]  mem_wdata,
   input  logic [7:0]  mem_rdata,
   input  logic        mem_ack,
   input  logic        mem_err
);

   logic              start;
   logic [ADDR_W-1:0] start_addr;
   logic              sel_load;
   logic [SEL_W-1:0]  sel_val;
   logic              adv_one;
   logic              adv_en;
   logic [CNT_W-1:0]  adv_amt;
   logic              has_data;
   logic [7:0]        cur_byte;
   logic [CNT_W-1:0]  remain;

   cfgdma_doorbell u_bell (
      .clk(clk), .rst_n(rst_n), .wr(db_wr), .off(db_off), .size(db_size),
      .wdata(db_wdata), .busy(busy), .start(start), .start_addr(start_addr)
   );

   cfgdma_items #(.NUM_ITEMS(NUM_ITEMS), .ITEM_LENS(ITEM_LENS)) u_items (
      .clk(clk), .rst_n(rst_n), .sel_load(sel_load), .sel_val(sel_val),
      .adv_one(adv_one), .adv_en(adv_en), .adv_amt(adv_amt),
      .has_data(has_data), .cur_byte(cur_byte), .remain(remain)
   );

   cfgdma_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .mem_err(mem_err), .sel_load(sel_load), .sel_val(sel_val),
      .adv_one(adv_one), .adv_en(adv_en), .adv_amt(adv_amt),
      .has_data(has_data), .cur_byte(cur_byte), .remain(remain)
   );

endmodule

// File: rtl/cfgdma_chk.sv
module cfgdma_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        db_wr,
   input logic [2:0]  db_off,
   input logic [3:0]  db_size,
   input logic        busy,
   input logic        mem_req,
   input logic        mem_we,
   input logic [63:0] mem_addr,
   input logic        mem_ack
);

   // R12
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(db_wr && ((db_size == 4'd8 && db_off == 3'd0) ||
                                      (db_size == 4'd4 && db_off == 3'd4))));

   // R1
   bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (db_wr && !busy && db_size != 4'd4 && db_size != 4'd8) |=> !busy);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R11
   status_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_ack && mem_we));

   // R12
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

endmodule

bind cfgdma_engine cfgdma_chk u_chk (
   .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_off(db_off),
   .db_size(db_size), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/cfgdma_engine_tb.sv
module cfgdma_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        db_wr = 1'b0;
   logic [2:0]  db_off = '0;
   logic [3:0]  db_size = '0;
   logic [63:0] db_wdata = '0;
   logic        busy, mem_req, mem_we;
   logic [63:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   cfgdma_engine u_dut (
      .clk(clk), .rst_n(rst_n), .db_wr(db_wr), .db_off(db_off),
      .db_size(db_size), .db_wdata(db_wdata), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .mem_err(mem_err)
   );

   // memory model: 256 bytes, aliased on the low address byte
   logic [7:0]  mem [256];
   logic        err_en = 1'b0;
   logic [63:0] err_addr = '0;
   int          n_wr = 0;
   int          n_rd = 0;
   int          n_start = 0;
   logic        want_first = 1'b0;
   logic [63:0] first_addr = '0;

   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         mem_err <= err_en && (mem_addr == err_addr);
         if (want_first) begin
            first_addr <= mem_addr;
            want_first <= 1'b0;
         end
         if (mem_we) begin
            n_wr <= n_wr + 1;
            if (!(err_en && mem_addr == err_addr)) mem[mem_addr[7:0]] <= mem_wdata;
         end else begin
            n_rd <= n_rd + 1;
            mem_rdata <= mem[mem_addr[7:0]];
         end
      end else begin
         mem_ack <= 1'b0;
         mem_err <= 1'b0;
      end
   end

   logic busy_d = 1'b0;
   always @(posedge clk) begin
      busy_d <= busy;
      if (busy && !busy_d) n_start <= n_start + 1;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ibyte(input int i, input int k);
      return 8'((i * 37 + k + 1) % 256);
   endfunction

   task automatic put_desc(input int a, input logic [31:0] ctl,
                           input logic [31:0] len, input logic [63:0] tgt);
      logic [127:0] d;
      d = {ctl, len, tgt};
      for (int b = 0; b < 16; b++) mem[(a + b) % 256] = d[127 - 8*b -: 8];
   endtask

   task automatic bell(input logic [2:0] o, input logic [3:0] s, input logic [63:0] v);
      @(negedge clk);
      db_wr = 1'b1; db_off = o; db_size = s; db_wdata = v;
      @(negedge clk);
      db_wr = 1'b0;
   endtask

   task automatic wait_idle();
      int t;
      t = 0;
      while (busy && t < 5000) begin @(negedge clk); t++; end
      if (t >= 5000) check("watchdog", 1, 0);
   endtask

   task automatic run(input int a, input logic [31:0] ctl,
                      input logic [31:0] len, input logic [63:0] tgt);
      put_desc(a, ctl, len, tgt);
      bell(3'd0, 4'd8, 64'(a));
      wait_idle();
   endtask

   task automatic check_stat(input string req, input int a, input logic [7:0] st);
      check(req, {mem[a], mem[a+1], mem[a+2], mem[a+3]}, {24'd0, st});
   endtask

   task automatic fill(input int a, input int n, input logic [7:0] v);
      for (int i = 0; i < n; i++) mem[a + i] = v;
   endtask

   task automatic t_reset();
      check("R13 busy", busy, 0);
      check("R13 mem_req", mem_req, 0);
   endtask

   task automatic t_default_item();
      int w0;
      fill(8'h80, 4, 8'hEE);
      w0 = n_wr;
      run(8'h00, 32'h2, 32'd3, 64'h80);
      for (int i = 0; i < 3; i++) check("R13 item0 empty zero", mem[8'h80 + i], 0);
      check("R6 no overrun", mem[8'h83], 8'hEE);
      check_stat("R11 ok", 8'h00, 0);
      check("R6 write count", n_wr - w0, 7);
   endtask

   task automatic t_select_read();
      int r0;
      r0 = n_rd;
      run(8'h10, {16'd2, 16'h000A}, 32'd4, 64'h90);
      for (int i = 0; i < 4; i++) check("R5 select read", mem[8'h90 + i], ibyte(2, i));
      check("R3 fetch reads", n_rd - r0, 16);
   endtask

   task automatic t_persist();
      run(8'h10, 32'h2, 32'd3, 64'hA0);
      for (int i = 0; i < 3; i++) check("R9 persist", mem[8'hA0 + i], ibyte(2, 4 + i));
   endtask

   task automatic t_skip_then_read();
      int w0;
      w0 = n_wr;
      run(8'h10, 32'h4, 32'd3, 64'hB0);
      check("R7 skip writes", n_wr - w0, 4);
      check_stat("R7 skip status", 8'h10, 0);
      // offset now 10 of 12: two data bytes then zero fill
      run(8'h10, 32'h2, 32'd4, 64'hB0);
      check("R7 after skip", mem[8'hB0], ibyte(2, 10));
      check("R7 after skip", mem[8'hB1], ibyte(2, 11));
      check("R6 zero fill", mem[8'hB2], 0);
      check("R6 zero fill", mem[8'hB3], 0);
      // skip past the end: offset stays at end, read still zero
      run(8'h10, 32'h4, 32'd50, 64'hB0);
      run(8'h10, 32'h2, 32'd1, 64'hB4);
      check("R7 skip clamp", mem[8'hB4], 0);
   endtask

   task automatic t_neither();
      int w0;
      run(8'h10, {16'd1, 16'h000A}, 32'd2, 64'hC8);
      w0 = n_wr;
      run(8'h10, 32'h0, 32'd5, 64'hC8);
      check("R8 no data", n_wr - w0, 4);
      run(8'h10, 32'h2, 32'd1, 64'hCA);
      check("R8 offset kept", mem[8'hCA], ibyte(1, 2));
      run(8'h10, {16'd1, 16'h0008}, 32'd9, 64'hC8);
      run(8'h10, 32'h2, 32'd6, 64'hD0);
      for (int i = 0; i < 5; i++) check("R5 reselect", mem[8'hD0 + i], ibyte(1, i));
      check("R6 end zero", mem[8'hD5], 0);
      run(8'h10, {16'd9, 16'h000A}, 32'd2, 64'hD8);
      check("R6 bad selector", mem[8'hD8], 0);
   endtask

   task automatic t_fetch_err();
      int w0;
      fill(8'h20, 4, 8'hEE);
      put_desc(8'h20, {16'd3, 16'h000A}, 32'd2, 64'hE0);
      fill(8'hE0, 2, 8'h55);
      err_en = 1'b1; err_addr = 64'h25;
      w0 = n_wr;
      bell(3'd0, 4'd8, 64'h20);
      wait_idle();
      err_en = 1'b0;
      check_stat("R4 fetch err", 8'h20, 8'h01);
      check("R4 no data", n_wr - w0, 4);
      check("R4 target untouched", mem[8'hE0], 8'h55);
   endtask

   task automatic t_write_err();
      fill(8'hC0, 3, 8'hEE);
      put_desc(8'h30, {16'd3, 16'h000A}, 32'd3, 64'hC0);
      err_en = 1'b1; err_addr = 64'hC1;
      bell(3'd0, 4'd8, 64'h30);
      wait_idle();
      err_en = 1'b0;
      check("R10 first byte", mem[8'hC0], ibyte(3, 0));
      check("R10 failed byte", mem[8'hC1], 8'hEE);
      check("R10 stop", mem[8'hC2], 8'hEE);
      check_stat("R10 status", 8'h30, 8'h01);
   endtask

   task automatic t_split_bell();
      int s0;
      put_desc(8'h40, 32'h0, 32'd0, 64'h0);
      s0 = n_start;
      bell(3'd0, 4'd4, 64'h1);
      bell(3'd4, 4'd2, 64'h40);
      bell(3'd2, 4'd4, 64'h40);
      repeat (3) @(negedge clk);
      check("R1 ignored writes", busy, 0);
      want_first = 1'b1;
      bell(3'd4, 4'd4, 64'h40);
      check("R1 busy rise", busy, 1);
      wait_idle();
      check("R1 split address", first_addr, 64'h1_0000_0040);
      want_first = 1'b1;
      bell(3'd4, 4'd4, 64'h40);
      wait_idle();
      check("R2 cleared", first_addr, 64'h40);
      check("R1 starts", n_start - s0, 2);
   endtask

   task automatic t_busy_ignore();
      int s0;
      s0 = n_start;
      put_desc(8'h50, 32'h2, 32'd4, 64'hF0);
      bell(3'd0, 4'd8, 64'h50);
      bell(3'd0, 4'd8, 64'h50);
      bell(3'd4, 4'd4, 64'h50);
      wait_idle();
      repeat (3) @(negedge clk);
      check("R12 idle after", busy, 0);
      check("R12 one start", n_start - s0, 1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_item();
      t_select_read();
      t_persist();
      t_skip_then_read();
      t_neither();
      t_fetch_err();
      t_write_err();
      t_split_bell();
      t_busy_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule